// File: doc/BRIEF.md
# Codec Register Access Bridge

This block lets a 32-bit memory-mapped host reach a byte-wide codec register file of up to 128 locations through two words on the host bus. The command word, at byte offset 0x4, holds an 8-bit data field in bits [7:0], a 7-bit register index in bits [14:8] and a write-start flag in bit 16. The status word, at byte offset 0x8, returns the settled read data in bits [7:0] and the live codec interrupt request in bit 8. A write begins when the host stores the command word with bit 16 set. The bridge then drives the codec write enable for a fixed number of cycles and clears bit 16 on its own when it is done, so the same bit serves as the busy flag the host polls.

A read is a store of the command word with bit 16 clear. This loads the index that the codec presents on its read port. The status data field does not follow the codec at once: it keeps its old value for a fixed settle time, counted in cycles, and only then takes the new byte. Software that reads a location back to confirm a write gets the new value once that settle time has passed. The exception is the codec's interrupt-flag locations, whose read value may differ from the value written.

The host interface is a single-cycle access: a store takes effect at the clock edge where `host_sel` and `host_wr` are both high, and reads are combinational on `host_addr`. The interface has no back-pressure. The host must respect the busy flag, and the bridge drops any command store made while busy is set.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, both fields of the command word are 0, bit 16 reads 0, `cdc_wr` is 0 and the status word's data field reads 0x00.
- R2: A store to offset 0x4 with bit 16 clear loads bits [7:0] into the data field and bits [14:8] into the index field. The command word reads back with these fields and with bit 15 and bits [31:17] at 0, and `cdc_wr` stays low.
- R3: A store to offset 0x4 with bit 16 set raises `cdc_wr` for exactly WR_CYCLES cycles, starting the cycle after the store, with `cdc_addr` and `cdc_wdata` equal to the stored fields. Bit 16 of the command word reads 1 over the same cycles and then clears itself.
- R4: A store to offset 0x4 while bit 16 reads 1 has no effect: the fields, `cdc_addr`, `cdc_wdata` and the write length stay as they were.
- R5: After a store with bit 16 clear, the status data field keeps its previous value for RD_LAT cycles. From the RD_LAT-th cycle after the store it shows the byte the codec returns for the new index.
- R6: After a write, the settle count starts only when bit 16 clears. The status data field shows the newly written byte RD_LAT cycles after the cycle in which busy drops, and shows the old value before that.
- R7: Bit 8 of the status word follows `cdc_irq` in the same cycle, and bits [31:9] of the status word read 0.
- R8: Stores to any offset other than 0x4 change nothing and start no write. Reads of offsets other than 0x4 and 0x8 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host store qualifier (1 = store) |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host store data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| cdc_addr | output | 7 | Codec register index |
| cdc_wdata | output | 8 | Codec write data |
| cdc_wr | output | 1 | Codec write enable, high during the write cycle |
| cdc_rdata | input | 8 | Codec read data for cdc_addr |
| cdc_irq | input | 1 | Codec interrupt request |

## Verification
The case that is hardest to reach from the ports is a command store that arrives while a write is still running. A correct host never makes one, and it is only visible if the bench sees that the fields and the write length did not change. The bench places such a store on the first busy cycle of every sixteenth write in a sweep over all 128 indices. It then reads the command word back and counts the cycles `cdc_wr` stays high. Every write is followed by a cycle-by-cycle check of the settle window after busy drops, and by a plain read of a different index. This covers both ways the settle count can start.

// File: rtl/cdc_bridge_pkg.sv
package cdc_bridge_pkg;
  // Word layout seen by the host; positions are decoded by software.
  localparam int DATA_W     = 8;
  localparam int IDX_W      = 7;
  localparam int IDX_LSB    = 8;
  localparam int GO_BIT     = 16;
  localparam int IRQ_BIT    = 8;
  localparam int CMD_OFFSET = 4;
  localparam int STS_OFFSET = 8;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } cmd_fields_t;
endpackage

// File: rtl/cdc_cmd_ctrl.sv
module cdc_cmd_ctrl
  import cdc_bridge_pkg::*;
#(
  parameter int WR_CYCLES = 3,
  parameter int HOST_AW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [GO_BIT:0]    host_wdata,
  output cmd_fields_t        fields,
  output logic               busy,
  output logic               accept
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] wr_left;
  logic          unused_bit15;

  assign unused_bit15 = host_wdata[IDX_LSB+IDX_W];
  assign accept = host_sel && host_wr && !busy &&
                  (host_addr == HOST_AW'(CMD_OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields  <= '0;
      busy    <= 1'b0;
      wr_left <= '0;
    end else if (accept) begin
      fields.data <= host_wdata[DATA_W-1:0];
      fields.idx  <= host_wdata[IDX_LSB +: IDX_W];
      if (host_wdata[GO_BIT]) begin
        busy    <= 1'b1;
        wr_left <= CW'(WR_CYCLES);
      end
    end else if (busy) begin
      if (wr_left == CW'(1)) busy <= 1'b0;
      wr_left <= wr_left - CW'(1);
    end
  end

  // Checker-side counter of consecutive busy cycles.
  logic [CW:0] bsy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bsy_len <= '0;
    else if (busy) bsy_len <= bsy_len + 1'b1;
    else           bsy_len <= '0;
  end

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_sel && host_wr && host_wdata[GO_BIT] &&
                          host_addr == HOST_AW'(CMD_OFFSET))); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bsy_len < (CW+1)'(WR_CYCLES))); // R3
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bsy_len) == (CW+1)'(WR_CYCLES - 1))); // R3
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fields)); // R4
endmodule

// File: rtl/cdc_read_settle.sv
module cdc_read_settle
  import cdc_bridge_pkg::*;
#(
  parameter int RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              hold,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_q
);
  localparam int LW = $clog2(RD_LAT + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      rd_q <= '0;
    end else if (restart) begin
      left <= LW'(RD_LAT);
    end else if (left != '0 && !hold) begin
      if (left == LW'(1)) rd_q <= din;
      left <= left - LW'(1);
    end
  end

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(left == LW'(1) && !hold && !restart) |-> $stable(rd_q)); // R5
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && !$past(restart)) |-> $stable(left)); // R6
endmodule

// File: rtl/cdc_host_rmux.sv
module cdc_host_rmux
  import cdc_bridge_pkg::*;
#(
  parameter int HOST_AW = 4
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  cmd_fields_t        fields,
  input  logic               busy,
  input  logic [DATA_W-1:0]  rd_q,
  input  logic               irq,
  output logic [31:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (host_addr == HOST_AW'(CMD_OFFSET)) begin
      rdata[DATA_W-1:0]        = fields.data;
      rdata[IDX_LSB +: IDX_W]  = fields.idx;
      rdata[GO_BIT]            = busy;
    end else if (host_addr == HOST_AW'(STS_OFFSET)) begin
      rdata[DATA_W-1:0] = rd_q;
      rdata[IRQ_BIT]    = irq;
    end
  end
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import cdc_bridge_pkg::*;
#(
  parameter int WR_CYCLES = 3,
  parameter int RD_LAT    = 4,
  parameter int HOST_AW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic [IDX_W-1:0]   cdc_addr,
  output logic [DATA_W-1:0]  cdc_wdata,
  output logic               cdc_wr,
  input  logic [DATA_W-1:0]  cdc_rdata,
  input  logic               cdc_irq
);
  cmd_fields_t       fields;
  logic              busy;
  logic              accept;
  logic [DATA_W-1:0] rd_q;
  logic              unused_hi;

  assign unused_hi = ^host_wdata[31:GO_BIT+1];

  cdc_cmd_ctrl #(.WR_CYCLES(WR_CYCLES), .HOST_AW(HOST_AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata[GO_BIT:0]),
    .fields(fields), .busy(busy), .accept(accept));

  cdc_read_settle #(.RD_LAT(RD_LAT)) u_settle (
    .clk(clk), .rst_n(rst_n), .restart(accept), .hold(busy),
    .din(cdc_rdata), .rd_q(rd_q));

  cdc_host_rmux #(.HOST_AW(HOST_AW)) u_rmux (
    .host_addr(host_addr), .fields(fields), .busy(busy), .rd_q(rd_q),
    .irq(cdc_irq), .rdata(host_rdata));

  assign cdc_addr  = fields.idx;
  assign cdc_wdata = fields.data;
  assign cdc_wr    = busy;

  AST_WR_MEANS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_wr && host_addr == HOST_AW'(CMD_OFFSET)) |-> host_rdata[GO_BIT]); // R3
endmodule

// File: tb/codec_reg_bridge_tb.sv
module codec_reg_bridge_tb;
  localparam int WR_CYCLES = 3;
  localparam int RD_LAT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [6:0]  cdc_addr;
  logic [7:0]  cdc_wdata;
  logic        cdc_wr;
  logic [7:0]  cdc_rdata;
  logic        cdc_irq = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] regs [128];
  logic [7:0] expv [128];
  logic [7:0] prev;

  always #2.5 clk = ~clk;

  codec_reg_bridge #(.WR_CYCLES(WR_CYCLES), .RD_LAT(RD_LAT), .HOST_AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata), .cdc_wr(cdc_wr),
    .cdc_rdata(cdc_rdata), .cdc_irq(cdc_irq));

  // Codec register file model
  always @(posedge clk) if (cdc_wr) regs[cdc_addr] <= cdc_wdata;
  assign cdc_rdata = regs[cdc_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] v);
    host_addr = off;
    #0.5;
    v = host_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input bit go, input logic [6:0] a, input logic [7:0] d);
    return {15'b0, go, 1'b0, a, d};
  endfunction

  task automatic settle_check(input logic [7:0] newv, input string req);
    logic [31:0] v;
    for (int k = 0; k < RD_LAT; k++) begin
      rd(4'h8, v);
      chk(v[7:0] == prev, {req, " hold"}, {24'b0, v[7:0]}, {24'b0, prev});
      @(negedge clk);
    end
    rd(4'h8, v);
    chk(v[7:0] == newv, {req, " settle"}, {24'b0, v[7:0]}, {24'b0, newv});
    prev = newv;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit inj);
    logic [31:0] v;
    int n;
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 4'h4; host_wdata = cmd_word(1'b1, a, d);
    @(negedge clk);
    host_sel = 0; host_wr = 0;
    rd(4'h4, v);
    chk(v == cmd_word(1'b1, a, d), "R3 busy bit and fields", v, cmd_word(1'b1, a, d));
    n = 0;
    while (cdc_wr && n < 20) begin
      n++;
      chk(cdc_addr == a && cdc_wdata == d, "R3 codec fields",
          {17'b0, cdc_addr, cdc_wdata}, {17'b0, a, d});
      if (inj && n == 1) begin
        host_sel = 1; host_wr = 1; host_addr = 4'h4;
        host_wdata = cmd_word(1'b1, ~a, ~d);
      end
      if (inj && n == 2) begin
        host_sel = 0; host_wr = 0;
        rd(4'h4, v);
        chk(v == cmd_word(1'b1, a, d), "R4 store while busy ignored", v, cmd_word(1'b1, a, d));
      end
      @(negedge clk);
    end
    chk(n == WR_CYCLES, "R3 write length", n, WR_CYCLES);
    rd(4'h4, v);
    chk(v == cmd_word(1'b0, a, d), "R3 busy self-clears", v, cmd_word(1'b0, a, d));
    expv[a] = d;
    settle_check(d, "R6");
  endtask

  task automatic do_read(input logic [6:0] a);
    logic [31:0] v;
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 4'h4; host_wdata = cmd_word(1'b0, a, 8'h00);
    @(negedge clk);
    host_sel = 0; host_wr = 0;
    rd(4'h4, v);
    chk(v == cmd_word(1'b0, a, 8'h00), "R2 plain load", v, cmd_word(1'b0, a, 8'h00));
    chk(cdc_wr == 1'b0, "R2 no codec write", {31'b0, cdc_wr}, 0);
    settle_check(expv[a], "R5");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 128; i++) begin
      regs[i] = 8'(i) ^ 8'h5A;
      expv[i] = 8'(i) ^ 8'h5A;
    end
    prev = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'h4, v); chk(v == 32'h0, "R1 command word", v, 0);
    rd(4'h8, v); chk(v == 32'h0, "R1 status word", v, 0);
    chk(cdc_wr == 1'b0, "R1 codec write idle", {31'b0, cdc_wr}, 0);
    // R7 interrupt line
    cdc_irq = 1; rd(4'h8, v);
    chk(v == 32'h100, "R7 irq high", v, 32'h100);
    cdc_irq = 0; rd(4'h8, v);
    chk(v == 32'h0, "R7 irq low", v, 0);
    // R8 other offsets
    for (int o = 0; o < 16; o += 4) begin
      if (o == 4) continue;
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_addr = 4'(o); host_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      host_sel = 0; host_wr = 0;
      chk(cdc_wr == 1'b0, "R8 no write started", {31'b0, cdc_wr}, 0);
      rd(4'h4, v); chk(v == 32'h0, "R8 command unchanged", v, 0);
      if (o != 8) begin
        rd(4'(o), v); chk(v == 32'h0, "R8 unmapped read", v, 0);
      end
    end
    // Sweep all indices
    for (int a = 0; a < 128; a++) begin
      do_write(7'(a), 8'((a * 37 + 5) & 8'hFF), (a % 16) == 3);
      do_read(7'(127 - a));
      do_read(7'(a));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule